// File: doc/BRIEF.md
# Serial Wiper Step Decoder with Lock and Protect Control

This block takes one-byte commands from a serial link framed by an active-low select line and turns them into steps of two 8-bit volatile wiper registers. A side input, `hv_cmd`, marks a command as carrying elevated authority. The same two opcodes, step-up and step-down, do different work depending on the address in the command. At the wiper addresses they move a wiper. At three non-volatile addresses, and only with elevated authority, they set or clear a per-wiper lock bit or a global protect bit.

Every lock or protect change starts a modelled non-volatile write. This write is a fixed count of clock cycles, and a busy output is high for all of it. While it runs, only commands to the volatile addresses are taken. Every other command is dropped. Commands are acted on when the select line returns high, never at the eighth serial clock. A frame that did not carry exactly eight serial clocks is discarded. Commands aimed at the control or reserved addresses, or carrying an unknown opcode, raise an error flag.

The serial lines are sampled with the system clock. The serial clock must therefore stay at each level for at least two system clocks.

Top module: `wiper_cmd_top`

## Requirements
- R1: A frame is the serial data captured on rising `spi_clk` edges while `spi_sel_n` is low, MSB first. Bits [7:4] are the address, bits [3:2] the opcode (01 = step up, 10 = step down), and bits [1:0] are ignored. A frame with any count of rising edges other than 8 has no effect on any output.
- R2: A command takes effect when `spi_sel_n` goes high. Its results appear one system clock after the first clock edge that samples `spi_sel_n` high, and nothing changes while select is still low.
- R3: At address 0 a step up adds one to wiper 0 and a step down subtracts one; address 1 does the same for wiper 1. Wipers saturate at 0 and 255 and never wrap.
- R4: With `hv_cmd` high, a step down at address 2 sets lock 0 and a step up clears it; address 3 does the same for lock 1.
- R5: With `hv_cmd` high, a step down at address 15 sets the protect bit and a step up clears it.
- R6: A wiper step with `hv_cmd` low is ignored while that wiper's lock bit is set; with `hv_cmd` high it is applied regardless of the lock.
- R7: An accepted command with an opcode other than 01 or 10, or aimed at address 4 through 14, or aimed at address 2, 3 or 15 with `hv_cmd` low, sets `cmd_err_o` and changes no wiper, lock or protect bit. Any other accepted command clears `cmd_err_o`.
- R8: Each accepted command at address 2, 3 or 15 with `hv_cmd` high starts a write. `nv_busy_o` goes high in the same cycle the bit changes and stays high for exactly `WR_CYCLES` clocks.
- R9: While `nv_busy_o` is high, only commands to addresses 0, 1, 4 and 5 are accepted. All others are dropped and leave the locks, the protect bit and `cmd_err_o` unchanged.
- R10: Select may go low again right after it goes high, and a wiper command sent during a write is carried out normally.
- R11: After reset both wipers hold `WIPER_RST` (default 128), and the locks, protect bit, busy and error outputs are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_clk | input | 1 | Serial clock, sampled by `clk` |
| spi_sel_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial command data |
| hv_cmd | input | 1 | Elevated-authority marker, sampled when select rises |
| wiper0_o | output | 8 | Wiper 0 value |
| wiper1_o | output | 8 | Wiper 1 value |
| lock0_o | output | 1 | Wiper 0 lock bit |
| lock1_o | output | 1 | Wiper 1 lock bit |
| wprot_o | output | 1 | Global protect bit |
| nv_busy_o | output | 1 | Modelled non-volatile write in progress |
| cmd_err_o | output | 1 | Last accepted command was invalid |

## Verification
The first clock edge that samples select high registers the frame. The next edge updates the wipers, locks, protect bit and error flag, and it also starts the busy count. All results are therefore due two edges after select is raised. The bench raises select on a falling edge and samples three falling edges later, when every result has settled. The timing test also samples one edge earlier and confirms that nothing has changed yet. The busy pulse is measured by counting falling-edge samples with busy high; the two samples already taken during the send are added back to give exactly `WR_CYCLES`.

// File: rtl/wiper_cmd_pkg.sv
package wiper_cmd_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_UP   = 2'b01,
    OP_DOWN = 2'b10,
    OP_BAD  = 2'b11
  } wiper_op_e;

  localparam logic [3:0] ADR_WIP0 = 4'h0;
  localparam logic [3:0] ADR_WIP1 = 4'h1;
  localparam logic [3:0] ADR_LCK0 = 4'h2;
  localparam logic [3:0] ADR_LCK1 = 4'h3;
  localparam logic [3:0] ADR_CTRL = 4'h4;
  localparam logic [3:0] ADR_RSV5 = 4'h5;
  localparam logic [3:0] ADR_PROT = 4'hF;
endpackage

// File: rtl/wiper_frame_rx.sv
module wiper_frame_rx #(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  spi_clk,
  input  logic                  spi_sel_n,
  input  logic                  spi_mosi,
  input  logic                  hv_in,
  output logic                  frm_stb,
  output logic                  frm_ok,
  output logic [FRAME_BITS-1:0] frm_byte,
  output logic                  frm_hv
);
  localparam int CW = $clog2(FRAME_BITS + 2);

  logic                  sclk_q;
  logic                  sel_q;
  logic [CW-1:0]         cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic                  sclk_rise;
  logic                  sel_rise;

  assign sclk_rise = spi_clk & ~sclk_q & ~spi_sel_n;
  assign sel_rise  = spi_sel_n & ~sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      sel_q    <= 1'b1;
      cnt      <= '0;
      shreg    <= '0;
      frm_stb  <= 1'b0;
      frm_ok   <= 1'b0;
      frm_byte <= '0;
      frm_hv   <= 1'b0;
    end else begin
      sclk_q  <= spi_clk;
      sel_q   <= spi_sel_n;
      frm_stb <= sel_rise;
      if (sel_rise) begin
        // R1: only an exact count of serial edges forms a valid frame
        frm_ok   <= (cnt == CW'(FRAME_BITS));
        frm_byte <= shreg;
        frm_hv   <= hv_in;
        cnt      <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[FRAME_BITS-2:0], spi_mosi};
        if (cnt != '1) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wiper_reg.sv
module wiper_reg #(
  parameter int WIDTH   = 8,
  parameter int RST_VAL = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_up,
  input  logic             step_dn,
  output logic [WIDTH-1:0] val
);
  always_ff @(posedge clk) begin
    if (rst) val <= WIDTH'(RST_VAL);
    else if (step_up && val != '1) val <= val + 1'b1;
    else if (step_dn && val != '0) val <= val - 1'b1;
  end

  // R3
  wiper_unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(val) |-> (val == $past(val) + 1'b1) || (val == $past(val) - 1'b1));

  // R3
  wiper_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !(($past(val) == '1 && val == '0) || ($past(val) == '0 && val == '1)));
endmodule

// File: rtl/wiper_nv_timer.sv
module wiper_nv_timer #(
  parameter int WR_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int TW = $clog2(WR_CYCLES + 1);

  logic [TW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) left <= '0;
    else if (start && left == '0) left <= TW'(WR_CYCLES);
    else if (left != '0) left <= left - 1'b1;
  end

  assign busy = (left != '0);

  // R8
  nv_busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R8
  nv_start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
endmodule

// File: rtl/wiper_cmd_top.sv
module wiper_cmd_top
  import wiper_cmd_pkg::*;
#(
  parameter int WIPER_W   = 8,
  parameter int WIPER_RST = 128,
  parameter int WR_CYCLES = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               spi_clk,
  input  logic               spi_sel_n,
  input  logic               spi_mosi,
  input  logic               hv_cmd,
  output logic [WIPER_W-1:0] wiper0_o,
  output logic [WIPER_W-1:0] wiper1_o,
  output logic               lock0_o,
  output logic               lock1_o,
  output logic               wprot_o,
  output logic               nv_busy_o,
  output logic               cmd_err_o
);
  localparam int NW = 2;
  localparam int FB = 8;

  logic          frm_stb, frm_ok, frm_hv;
  logic [FB-1:0] frm_byte;
  logic [3:0]    addr;
  wiper_op_e     op;
  logic          is_vol, accept, op_ok, go_up;
  logic [NW-1:0] step_up, step_dn, lock_q, lock_d;
  logic          prot_d, prot_q, err_q, set_err, clr_err, nv_start;
  logic [WIPER_W-1:0] wval [NW];

  wiper_frame_rx #(.FRAME_BITS(FB)) u_rx (
    .clk(clk), .rst(rst), .spi_clk(spi_clk), .spi_sel_n(spi_sel_n),
    .spi_mosi(spi_mosi), .hv_in(hv_cmd), .frm_stb(frm_stb),
    .frm_ok(frm_ok), .frm_byte(frm_byte), .frm_hv(frm_hv)
  );

  assign addr   = frm_byte[7:4];
  assign op     = wiper_op_e'(frm_byte[3:2]);
  assign op_ok  = (op == OP_UP) || (op == OP_DOWN);
  assign go_up  = (op == OP_UP);
  // R9: only volatile targets pass while a write is running
  assign is_vol = (addr == ADR_WIP0) || (addr == ADR_WIP1) ||
                  (addr == ADR_CTRL) || (addr == ADR_RSV5);
  assign accept = frm_stb && frm_ok && (!nv_busy_o || is_vol);

  always_comb begin
    step_up  = '0;
    step_dn  = '0;
    lock_d   = lock_q;
    prot_d   = prot_q;
    set_err  = 1'b0;
    clr_err  = 1'b0;
    nv_start = 1'b0;
    if (accept) begin
      if (!op_ok) begin
        set_err = 1'b1;
      end else begin
        case (addr)
          ADR_WIP0, ADR_WIP1: begin
            clr_err = 1'b1;
            // R6: a locked wiper moves only on elevated commands
            if (!lock_q[addr[0]] || frm_hv) begin
              step_up[addr[0]] = go_up;
              step_dn[addr[0]] = !go_up;
            end
          end
          ADR_LCK0, ADR_LCK1: begin
            if (frm_hv) begin
              lock_d[addr[0]] = !go_up;
              nv_start        = 1'b1;
              clr_err         = 1'b1;
            end else begin
              set_err = 1'b1;
            end
          end
          ADR_PROT: begin
            if (frm_hv) begin
              prot_d   = !go_up;
              nv_start = 1'b1;
              clr_err  = 1'b1;
            end else begin
              set_err = 1'b1;
            end
          end
          default: set_err = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= '0;
      prot_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      lock_q <= lock_d;
      prot_q <= prot_d;
      if (set_err) err_q <= 1'b1;
      else if (clr_err) err_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_wiper
    wiper_reg #(.WIDTH(WIPER_W), .RST_VAL(WIPER_RST)) u_wiper (
      .clk(clk), .rst(rst), .step_up(step_up[g]), .step_dn(step_dn[g]),
      .val(wval[g])
    );
  end

  wiper_nv_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(nv_start), .busy(nv_busy_o)
  );

  assign wiper0_o  = wval[0];
  assign wiper1_o  = wval[1];
  assign lock0_o   = lock_q[0];
  assign lock1_o   = lock_q[1];
  assign wprot_o   = prot_q;
  assign cmd_err_o = err_q;

  // R9
  busy_holds_locks_chk: assert property (@(posedge clk) disable iff (rst)
    $past(nv_busy_o) |-> ($stable(lock_q) && $stable(prot_q)));

  // R4
  lock_needs_hv_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(lock_q) |-> $past(frm_stb && frm_ok && frm_hv));

  // R5
  prot_needs_hv_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(prot_q) |-> $past(frm_stb && frm_ok && frm_hv));
endmodule

// File: tb/wiper_cmd_top_bench.sv
module wiper_cmd_top_bench;
  localparam int WR = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_clk = 1'b0, spi_sel_n = 1'b1, spi_mosi = 1'b0, hv_cmd = 1'b0;
  logic [7:0] w0, w1;
  logic lk0, lk1, wp, busy, err;
  int n_run = 0, n_fail = 0;
  int e0 = 128, e1 = 128;

  always #5 clk = ~clk;

  wiper_cmd_top #(.WR_CYCLES(WR)) u_wiper_cmd_top (
    .clk(clk), .rst(rst), .spi_clk(spi_clk), .spi_sel_n(spi_sel_n),
    .spi_mosi(spi_mosi), .hv_cmd(hv_cmd), .wiper0_o(w0), .wiper1_o(w1),
    .lock0_o(lk0), .lock1_o(lk1), .wprot_o(wp), .nv_busy_o(busy),
    .cmd_err_o(err)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic shift_bits(input logic [3:0] a, input logic [1:0] op,
                            input logic hv, input int nb);
    logic [7:0] b;
    b = {a, op, 2'b00};
    hv_cmd = hv;
    @(negedge clk) spi_sel_n = 1'b0;
    for (int i = 0; i < nb; i++) begin
      spi_mosi = (i < 8) ? b[7-i] : 1'b0;
      repeat (2) @(negedge clk);
      spi_clk = 1'b1;
      repeat (2) @(negedge clk);
      spi_clk = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [3:0] a, input logic [1:0] op,
                      input logic hv, input int nb);
    shift_bits(a, op, hv, nb);
    spi_sel_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < WR + 20 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 wiper0 reset", w0, 128);
    chk("R11 wiper1 reset", w1, 128);
    chk("R11 lock0 reset", lk0, 0);
    chk("R11 lock1 reset", lk1, 0);
    chk("R11 prot reset", wp, 0);
    chk("R11 busy reset", busy, 0);
    chk("R11 err reset", err, 0);
  endtask

  task automatic t_steps();
    send(4'h0, 2'b01, 1'b0, 8); e0++;
    chk("R3 wiper0 up", w0, e0);
    send(4'h0, 2'b10, 1'b0, 8); e0--;
    send(4'h0, 2'b10, 1'b0, 8); e0--;
    chk("R3 wiper0 down", w0, e0);
    send(4'h1, 2'b10, 1'b0, 8); e1--;
    chk("R3 wiper1 down", w1, e1);
    chk("R3 wiper0 untouched", w0, e0);
  endtask

  task automatic t_timing();
    shift_bits(4'h0, 2'b01, 1'b0, 8);
    repeat (3) @(negedge clk);
    chk("R2 no change before select high", w0, e0);
    spi_sel_n = 1'b1;
    @(negedge clk);
    chk("R2 no change one edge after", w0, e0);
    @(negedge clk); e0++;
    chk("R2 change two edges after", w0, e0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 140; i++) send(4'h0, 2'b01, 1'b0, 8);
    e0 = 255;
    chk("R3 wiper0 sat high", w0, 255);
    for (int i = 0; i < 140; i++) send(4'h1, 2'b10, 1'b0, 8);
    e1 = 0;
    chk("R3 wiper1 sat low", w1, 0);
  endtask

  task automatic t_malformed();
    send(4'h2, 2'b10, 1'b1, 7);
    chk("R1 7-clock frame lock0", lk0, 0);
    chk("R1 7-clock frame busy", busy, 0);
    send(4'h1, 2'b01, 1'b0, 9);
    chk("R1 9-clock frame wiper1", w1, e1);
    chk("R1 9-clock frame err", err, 0);
  endtask

  task automatic t_locks();
    int cnt;
    send(4'h2, 2'b10, 1'b1, 8);
    chk("R4 lock0 set", lk0, 1);
    cnt = 0;
    while (busy && cnt < WR + 20) begin
      @(negedge clk);
      if (busy) cnt++;
    end
    chk("R8 busy length", cnt + 2, WR);
    send(4'h0, 2'b10, 1'b0, 8);
    chk("R6 locked wiper0 ignores plain step", w0, e0);
    send(4'h0, 2'b10, 1'b1, 8); e0--;
    chk("R6 locked wiper0 takes elevated step", w0, e0);
    send(4'h2, 2'b01, 1'b1, 8);
    chk("R4 lock0 clear", lk0, 0);
    wait_idle();
    send(4'h3, 2'b10, 1'b1, 8);
    chk("R4 lock1 set", lk1, 1);
    wait_idle();
    send(4'h3, 2'b01, 1'b1, 8);
    chk("R4 lock1 clear", lk1, 0);
    wait_idle();
  endtask

  task automatic t_protect();
    send(4'hF, 2'b10, 1'b1, 8);
    chk("R5 protect set", wp, 1);
    chk("R8 busy after protect", busy, 1);
    wait_idle();
    send(4'hF, 2'b01, 1'b1, 8);
    chk("R5 protect clear", wp, 0);
    wait_idle();
  endtask

  task automatic t_errors();
    send(4'h4, 2'b01, 1'b0, 8);
    chk("R7 control addr err", err, 1);
    send(4'h0, 2'b01, 1'b0, 8); e0 = (e0 < 255) ? e0 + 1 : 255;
    chk("R7 valid clears err", err, 0);
    send(4'h7, 2'b10, 1'b1, 8);
    chk("R7 reserved addr err", err, 1);
    send(4'h0, 2'b00, 1'b0, 8);
    chk("R7 bad opcode err", err, 1);
    chk("R7 bad opcode wiper0", w0, e0);
    send(4'h0, 2'b11, 1'b0, 8);
    chk("R7 opcode 11 wiper0", w0, e0);
    send(4'h2, 2'b10, 1'b0, 8);
    chk("R7 lock addr without hv err", err, 1);
    chk("R7 lock addr without hv lock0", lk0, 0);
    chk("R7 lock addr without hv busy", busy, 0);
    send(4'h1, 2'b01, 1'b0, 8); e1++;
  endtask

  task automatic t_gating();
    send(4'h2, 2'b10, 1'b1, 8);
    chk("R9 lock0 set starts write", lk0, 1);
    send(4'h1, 2'b01, 1'b0, 8); e1++;
    chk("R10 wiper1 step during write", w1, e1);
    send(4'h3, 2'b10, 1'b1, 8);
    chk("R9 lock1 dropped during write", lk1, 0);
    chk("R9 err unchanged on drop", err, 0);
    send(4'hF, 2'b10, 1'b1, 8);
    chk("R9 protect dropped during write", wp, 0);
    send(4'h4, 2'b01, 1'b0, 8);
    chk("R9 control addr accepted during write", err, 1);
    chk("R9 still busy", busy, 1);
    wait_idle();
    chk("R9 busy ends", busy, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_steps();
    t_timing();
    t_saturate();
    t_malformed();
    t_locks();
    t_protect();
    t_errors();
    t_gating();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule